// File: doc/BRIEF.md
# Scalable Multi-Copy Sprite Generator

This block turns an 8-bit graphics pattern into a one-bit-per-clock pixel stream for a single sprite on a raster line. A size code picks the layout: one, two or three copies spaced on a 16-pixel grid, or one copy stretched to twice or four times its width. A mirror input reverses the left-to-right order of the pattern. A vertical-delay option shows the pattern as it was captured at the last start-of-line pulse instead of the live value.

The block counts its own raster line. A beam counter runs from the start-of-line pulse, or from its own wrap, through a blanking interval and then the visible interval. A separate sprite position counter advances only on visible clocks and wraps at the visible width. A position-reset strobe sets that counter to zero, so the first copy starts on the clock after the strobe. Fine motion and missile objects belong elsewhere.

Top module: `sprite_copy_gen`

## Requirements
- R1: `pix_on` is 0 while the beam count is below 68. The beam count is 0 on the clock after a `line_start` pulse, and it starts at 0 when reset is released.
- R2: With no `line_start` pulse, the beam count goes from 227 back to 0, so a line lasts 228 clocks.
- R3: The sprite position counter advances by one only on clocks where the beam count is 68 or more. On other clocks it holds. It goes from 159 back to 0.
- R4: A `pos_rst` pulse, whatever the other inputs are, sets the position counter to 0 on the next clock. The strobe takes priority over advancing.
- R5: With `size_code` 0, one 8-pixel copy covers positions 0 to 7.
- R6: With `size_code` 1, 2 or 4, two 8-pixel copies start at positions 0 and 16, 0 and 32, or 0 and 64.
- R7: With `size_code` 3, three copies start at 0, 16 and 32. With `size_code` 6, they start at 0, 32 and 64.
- R8: With `size_code` 5, one copy covers positions 0 to 15 with each bit held for 2 clocks. With `size_code` 7, one copy covers positions 0 to 31 with each bit held for 4 clocks.
- R9: With `mirror` at 0, pixel index i of a copy (i from 0 to 7, left to right) shows `gfx[7-i]`.
- R10: With `mirror` at 1, pixel index i of a copy shows `gfx[i]`.
- R11: The block captures `gfx` on every `line_start` pulse. With `vdelay_en` at 1, the pixels come from that captured value and not from the live `gfx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Start-of-line pulse; restarts the beam count and captures `gfx` |
| pos_rst | input | 1 | Position-reset strobe |
| gfx | input | 8 | Sprite graphics pattern |
| size_code | input | 3 | Copies and stretch selector |
| mirror | input | 1 | Reverse the pixel order |
| vdelay_en | input | 1 | Use the pattern captured at the last start-of-line |
| pix_on | output | 1 | Sprite pixel active |

## Verification
The hard case is the vertical delay. To show it, the captured pattern and the live pattern must differ on the same line, and the copies must land inside the visible interval. In each test line the bench therefore captures one pattern with the `line_start` pulse and changes `gfx` to a second pattern on the very next clock. It then runs a second line that starts from the wrap alone, with no new pulse. The delayed output must still show the first pattern across both lines, while the live output shows the second. Each combination of size code, mirror and delay uses its own strobe offset, so copies also cross the 160-position wrap.

// File: rtl/spr_gen_pkg.sv
package spr_gen_pkg;

    localparam int GFX_BITS  = 8;
    localparam int SLOT_PX   = 16;
    localparam int MAX_SLOTS = 5;

    typedef enum logic [2:0] {
        SZ_ONE        = 3'd0,
        SZ_TWO_NEAR   = 3'd1,
        SZ_TWO_MID    = 3'd2,
        SZ_THREE_NEAR = 3'd3,
        SZ_TWO_FAR    = 3'd4,
        SZ_DOUBLE     = 3'd5,
        SZ_THREE_MID  = 3'd6,
        SZ_QUAD       = 3'd7
    } size_code_e;

    typedef enum logic [1:0] {
        SCALE_X1 = 2'd0,
        SCALE_X2 = 2'd1,
        SCALE_X4 = 2'd2
    } scale_e;

    // slots: one bit per 16-pixel grid cell holding a copy start
    typedef struct packed {
        logic [MAX_SLOTS-1:0] slots;
        scale_e               scale;
    } shape_t;

    function automatic shape_t decode_shape(size_code_e code);
        shape_t s;
        s.scale = SCALE_X1;
        unique case (code)
            SZ_ONE:        s.slots = 5'b00001;
            SZ_TWO_NEAR:   s.slots = 5'b00011;
            SZ_TWO_MID:    s.slots = 5'b00101;
            SZ_THREE_NEAR: s.slots = 5'b00111;
            SZ_TWO_FAR:    s.slots = 5'b10001;
            SZ_THREE_MID:  s.slots = 5'b10101;
            SZ_DOUBLE: begin
                s.slots = 5'b00001;
                s.scale = SCALE_X2;
            end
            SZ_QUAD: begin
                s.slots = 5'b00001;
                s.scale = SCALE_X4;
            end
            default:       s.slots = 5'b00001;
        endcase
        return s;
    endfunction

    // leftmost pixel shows the MSB unless mirrored
    function automatic logic [2:0] bit_for_pixel(logic [2:0] px, logic mirror);
        return mirror ? px : (3'd7 - px);
    endfunction

endpackage

// File: rtl/spr_beam_timer.sv
module spr_beam_timer #(
    parameter int LINE_CLKS   = 228,
    parameter int HBLANK_CLKS = 68
) (
    input  logic clk,
    input  logic rst,
    input  logic line_start,
    output logic visible
);
    localparam int HW = $clog2(LINE_CLKS);
    localparam logic [HW-1:0] LAST  = HW'(LINE_CLKS - 1);
    localparam logic [HW-1:0] FIRST_VIS = HW'(HBLANK_CLKS);

    logic [HW-1:0] hcnt_q;

    always_ff @(posedge clk) begin
        if (rst || line_start) begin
            hcnt_q <= '0;
        end else if (hcnt_q == LAST) begin
            hcnt_q <= '0;
        end else begin
            hcnt_q <= hcnt_q + 1'b1;
        end
    end

    assign visible = (hcnt_q >= FIRST_VIS);

    a_r2_line_wrap: assert property (@(posedge clk) disable iff (rst)
        (hcnt_q == LAST && !line_start) |=> (hcnt_q == '0));

    a_r1_blank_after_start: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !visible);

endmodule

// File: rtl/spr_pos_counter.sv
module spr_pos_counter #(
    parameter int VIS_CLKS = 160,
    parameter int POS_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             pos_rst,
    output logic [POS_W-1:0] pos
);
    localparam logic [POS_W-1:0] LAST = POS_W'(VIS_CLKS - 1);

    logic [POS_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst || pos_rst) begin
            pos_q <= '0;
        end else if (advance) begin
            pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
        end
    end

    assign pos = pos_q;

    a_r4_strobe_zero: assert property (@(posedge clk) disable iff (rst)
        pos_rst |=> (pos == '0));

    a_r3_hold_in_blank: assert property (@(posedge clk) disable iff (rst)
        (!advance && !pos_rst) |=> $stable(pos));

    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (advance && !pos_rst && pos == LAST) |=> (pos == '0));

endmodule

// File: rtl/spr_gfx_select.sv
module spr_gfx_select #(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_start,
    input  logic          vdelay_en,
    input  logic [GW-1:0] gfx_live,
    output logic [GW-1:0] gfx_shown
);
    logic [GW-1:0] gfx_held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gfx_held_q <= '0;
        end else if (line_start) begin
            gfx_held_q <= gfx_live;
        end
    end

    assign gfx_shown = vdelay_en ? gfx_held_q : gfx_live;

    a_r11_capture: assert property (@(posedge clk) disable iff (rst)
        (line_start ##1 vdelay_en) |-> (gfx_shown == $past(gfx_live)));

endmodule

// File: rtl/spr_serializer.sv
module spr_serializer
    import spr_gen_pkg::*;
#(
    parameter int POS_W = 8
) (
    input  logic [POS_W-1:0]    pos,
    input  logic [GFX_BITS-1:0] gfx,
    input  logic [2:0]          size_code,
    input  logic                mirror,
    input  logic                visible,
    output logic                pix
);
    shape_t     shape;
    logic       hit;
    logic [2:0] px_idx;

    always_comb begin
        int p;
        shape  = decode_shape(size_code_e'(size_code));
        p      = int'(pos);
        hit    = 1'b0;
        px_idx = 3'd0;
        unique case (shape.scale)
            SCALE_X2: begin
                hit    = (p < 2 * GFX_BITS);
                px_idx = 3'(p >> 1);
            end
            SCALE_X4: begin
                hit    = (p < 4 * GFX_BITS);
                px_idx = 3'(p >> 2);
            end
            default: begin
                for (int s = 0; s < MAX_SLOTS; s++) begin
                    if (shape.slots[s] && p >= s * SLOT_PX
                        && p < s * SLOT_PX + GFX_BITS) begin
                        hit    = 1'b1;
                        px_idx = 3'(p - s * SLOT_PX);
                    end
                end
            end
        endcase
        pix = visible & hit & gfx[bit_for_pixel(px_idx, mirror)];
    end

endmodule

// File: rtl/sprite_copy_gen.sv
module sprite_copy_gen
    import spr_gen_pkg::*;
#(
    parameter int LINE_CLKS   = 228,
    parameter int HBLANK_CLKS = 68
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                line_start,
    input  logic                pos_rst,
    input  logic [GFX_BITS-1:0] gfx,
    input  logic [2:0]          size_code,
    input  logic                mirror,
    input  logic                vdelay_en,
    output logic                pix_on
);
    localparam int VIS_CLKS = LINE_CLKS - HBLANK_CLKS;
    localparam int POS_W    = $clog2(VIS_CLKS);

    logic                visible_w;
    logic [POS_W-1:0]    pos_w;
    logic [GFX_BITS-1:0] gfx_w;

    spr_beam_timer #(
        .LINE_CLKS  (LINE_CLKS),
        .HBLANK_CLKS(HBLANK_CLKS)
    ) timer_i (
        .clk       (clk),
        .rst       (rst),
        .line_start(line_start),
        .visible   (visible_w)
    );

    spr_pos_counter #(
        .VIS_CLKS(VIS_CLKS),
        .POS_W   (POS_W)
    ) pos_i (
        .clk    (clk),
        .rst    (rst),
        .advance(visible_w),
        .pos_rst(pos_rst),
        .pos    (pos_w)
    );

    spr_gfx_select #(
        .GW(GFX_BITS)
    ) sel_i (
        .clk       (clk),
        .rst       (rst),
        .line_start(line_start),
        .vdelay_en (vdelay_en),
        .gfx_live  (gfx),
        .gfx_shown (gfx_w)
    );

    spr_serializer #(
        .POS_W(POS_W)
    ) ser_i (
        .pos      (pos_w),
        .gfx      (gfx_w),
        .size_code(size_code),
        .mirror   (mirror),
        .visible  (visible_w),
        .pix      (pix_on)
    );

    a_r1_dark_in_blank: assert property (@(posedge clk) disable iff (rst)
        !visible_w |-> !pix_on);

    a_r8_quad_extent: assert property (@(posedge clk) disable iff (rst)
        (size_code == 3'd7 && pos_w >= POS_W'(32)) |-> !pix_on);

    a_r5_single_extent: assert property (@(posedge clk) disable iff (rst)
        (size_code == 3'd0 && pos_w >= POS_W'(8)) |-> !pix_on);

endmodule

// File: tb/sprite_copy_gen_tb_top.sv
module sprite_copy_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_start = 1'b0;
    logic       pos_rst = 1'b0;
    logic [7:0] gfx = 8'h00;
    logic [2:0] size_code = 3'd0;
    logic       mirror = 1'b0;
    logic       vdelay_en = 1'b0;
    logic       pix_on;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int m_beam = 0;
    int m_pos  = 0;
    logic [7:0] m_held = 8'h00;

    always #2.5 clk = ~clk;

    sprite_copy_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .line_start(line_start),
        .pos_rst   (pos_rst),
        .gfx       (gfx),
        .size_code (size_code),
        .mirror    (mirror),
        .vdelay_en (vdelay_en),
        .pix_on    (pix_on)
    );

    function automatic logic exp_pattern(int p, int code, logic refl, logic [7:0] g);
        int starts[3];
        int n;
        int k;
        starts = '{0, 0, 0};
        n = 1;
        k = 1;
        case (code)
            1: begin n = 2; starts[1] = 16; end
            2: begin n = 2; starts[1] = 32; end
            3: begin n = 3; starts[1] = 16; starts[2] = 32; end
            4: begin n = 2; starts[1] = 64; end
            5: k = 2;
            6: begin n = 3; starts[1] = 32; starts[2] = 64; end
            7: k = 4;
            default: ;
        endcase
        for (int i = 0; i < n; i++) begin
            int d;
            d = p - starts[i];
            if (d >= 0 && d < 8 * k) begin
                int ix;
                ix = d / k;
                return refl ? g[ix] : g[7 - ix];
            end
        end
        return 1'b0;
    endfunction

    function automatic string code_tag(int code);
        case (code)
            0: return "R5";
            1, 2, 4: return "R6";
            3, 6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s beam=%0d pos=%0d actual=%0b expected=%0b",
                     req, m_beam, m_pos, act, exp);
        end
    endtask

    // One clock: apply the pulses, update the arithmetic model, compare.
    task automatic tick(logic ls, logic st, bit second_line);
        logic vis_now;
        logic exp;
        string req;
        line_start = ls;
        pos_rst    = st;
        @(posedge clk);
        vis_now = (m_beam >= 68);
        if (ls) m_held = gfx;
        m_beam = ls ? 0 : ((m_beam == 227) ? 0 : m_beam + 1);       // R2 wrap
        if (st) m_pos = 0;                                         // R4
        else if (vis_now) m_pos = (m_pos == 159) ? 0 : m_pos + 1;  // R3
        #1;
        if (m_beam < 68) begin
            exp = 1'b0;
            req = "R1";
        end else begin
            exp = exp_pattern(m_pos, int'(size_code), mirror,
                              vdelay_en ? m_held : gfx);
            req = {code_tag(int'(size_code)), mirror ? " R10" : " R9",
                   vdelay_en ? " R11" : "", " R3 R4", second_line ? " R2" : ""};
        end
        check_bit(req, pix_on, exp);
        line_start = 1'b0;
        pos_rst    = 1'b0;
    endtask

    initial begin
        logic [7:0] pat_a [3];
        logic [7:0] pat_b [3];
        pat_a = '{8'hA5, 8'h81, 8'h01};
        pat_b = '{8'h3C, 8'hF0, 8'h80};

        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        m_beam = 0;
        m_pos  = 0;
        m_held = 8'h00;
        check_bit("R1", pix_on, 1'b0);   // reset state: blank

        for (int code = 0; code < 8; code++) begin
            for (int rf = 0; rf < 2; rf++) begin
                for (int vd = 0; vd < 2; vd++) begin
                    for (int pt = 0; pt < 3; pt++) begin
                        int cfg;
                        int soff;
                        int blank_st;
                        cfg = ((code * 2 + rf) * 2 + vd) * 3 + pt;
                        soff = (cfg * 13) % 90;
                        blank_st = (cfg % 4 == 0) ? 20 : -1;
                        size_code = 3'(code);
                        mirror    = rf[0];
                        vdelay_en = vd[0];
                        gfx       = pat_a[pt];
                        tick(1'b1, 1'b0, 1'b0);        // captures pat_a (R11)
                        gfx = pat_b[pt];
                        for (int c = 1; c < 228; c++) begin
                            tick(1'b0, (c == 68 + soff) || (c == blank_st), 1'b0);
                        end
                        for (int c = 0; c < 228; c++) begin
                            tick(1'b0, 1'b0, 1'b1);    // line started by wrap (R2)
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule